// File: doc/BRIEF.md
# Cycle-Steal Block Transfer Channel

This block moves a block of words between main storage and a single peripheral without help from the running program. Software issues one initiate command holding a function code and a starting storage address. The channel then runs on its own. It steals one storage cycle per word from the storage arbiter, steps its own address pointer and counts down its own word total. The CPU only waits during the cycles the channel has been granted.

The first word at the starting address is not data. It holds the number of words to move, and the data block starts one location above it. Initiate-write reads words from storage and hands them to the device. Initiate-read takes words from the device and stores them. When the count runs out, the channel drops its busy output and raises a level interrupt, which stays high until it is acknowledged.

Control and sense commands for the same device stay with the program and never reach this block. Every function code other than the two initiate codes is ignored.

Top module: `steal_chan`

## Requirements
- R1: Only function code 3'b101 (initiate-write) or 3'b110 (initiate-read) with cmd_valid high in an idle cycle starts a transfer; every other code leaves busy low and issues no storage request.
- R2: The first storage cycle of a transfer reads the count word at cmd_addr; if that word is zero the transfer ends right after this single cycle, with no data moved.
- R3: An initiate-write with count N reads storage locations cmd_addr+1 through cmd_addr+N in ascending order and presents each word on dev_out_data, holding it until dev_out_ready is high.
- R4: An initiate-read with count N accepts N device words, one per dev_in_valid/dev_in_ready handshake, and writes them in order to cmd_addr+1 through cmd_addr+N.
- R5: Once mem_req is raised it stays high, with mem_addr and mem_we unchanged, until a cycle in which mem_gnt is high.
- R6: A transfer of N words uses exactly N+1 granted storage cycles, and each storage cycle within a transfer addresses the location one above the previous one.
- R7: In the cycle after the last word completes, busy is low and irq is high; irq then stays high until irq_ack is sampled high.
- R8: An initiate command that arrives while busy is high is ignored and sets the rejected flag; the flag clears when the next command is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_func | input | 3 | Function code |
| cmd_addr | input | AW | Address of the count word |
| busy | output | 1 | Transfer in progress |
| rejected | output | 1 | An initiate was refused while busy |
| mem_req | output | 1 | Storage cycle request |
| mem_we | output | 1 | Request is a store (1) or a fetch (0) |
| mem_addr | output | AW | Storage address of the request |
| mem_wdata | output | DW | Store data |
| mem_rdata | input | DW | Fetch data, valid in the granted cycle |
| mem_gnt | input | 1 | Storage cycle granted this clock |
| dev_out_valid | output | 1 | Word offered to the device |
| dev_out_data | output | DW | Word for the device |
| dev_out_ready | input | 1 | Device takes the offered word |
| dev_in_valid | input | 1 | Device offers a word |
| dev_in_data | input | DW | Word from the device |
| dev_in_ready | output | 1 | Channel takes the device word |
| irq | output | 1 | End-of-block interrupt, level |
| irq_ack | input | 1 | Interrupt acknowledge |

## Verification
The hardest case to reach is a second initiate that lands in the middle of a running block, because it must not disturb the address, the count or the storage area it names. The bench starts a slow write transfer with a sparse grant and ready pattern. A few cycles in, it issues an initiate-read aimed at a separately seeded region. It then checks that the rejected flag rises, that the original block still arrives intact and that the second region is never written. The main sweep covers both directions, every count from zero to five and three grant and handshake stall patterns, so that a request waiting for its grant coincides with both transfer states.

// File: rtl/steal_pkg.sv
package steal_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_FETCH = 3'd1,
      ST_MRD   = 3'd2,
      ST_DPUT  = 3'd3,
      ST_DGET  = 3'd4,
      ST_MWR   = 3'd5
   } chan_state_e;

   localparam logic [2:0] FN_INIT_WR = 3'b101;
   localparam logic [2:0] FN_INIT_RD = 3'b110;

   function automatic logic is_initiate(input logic [2:0] f);
      return (f == FN_INIT_WR) || (f == FN_INIT_RD);
   endfunction
endpackage

// File: rtl/steal_ptr.sv
module steal_ptr #(
   parameter int AW = 16,
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_addr,
   input  logic [AW-1:0] addr_in,
   input  logic          step_addr,
   input  logic          load_cnt,
   input  logic [CW-1:0] cnt_in,
   input  logic          dec_cnt,
   output logic [AW-1:0] addr,
   output logic          cnt_last
);
   localparam logic [AW-1:0] ADDR_ONE = AW'(1);
   localparam logic [CW-1:0] CNT_ONE  = CW'(1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr  <= '0;
         cnt_q <= '0;
      end else begin
         if (load_addr)      addr <= addr_in;
         else if (step_addr) addr <= addr + ADDR_ONE;
         if (load_cnt)       cnt_q <= cnt_in;
         else if (dec_cnt)   cnt_q <= cnt_q - CNT_ONE;
      end
   end

   assign cnt_last = (cnt_q == CNT_ONE);
endmodule

// File: rtl/steal_seq.sv
module steal_seq
   import steal_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cmd_valid,
   input  logic [2:0]  cmd_func,
   input  logic        mem_gnt,
   input  logic        cnt_word_zero,
   input  logic        cnt_last,
   input  logic        dev_out_ready,
   input  logic        dev_in_valid,
   output chan_state_e state,
   output logic        accept,
   output logic        refuse,
   output logic        done,
   output logic        load_cnt,
   output logic        step_addr,
   output logic        dec_cnt,
   output logic        cap_mem,
   output logic        cap_dev
);
   chan_state_e nxt;
   logic        to_dev_q;

   always_comb begin
      nxt       = state;
      accept    = 1'b0;
      refuse    = 1'b0;
      done      = 1'b0;
      load_cnt  = 1'b0;
      step_addr = 1'b0;
      dec_cnt   = 1'b0;
      cap_mem   = 1'b0;
      cap_dev   = 1'b0;
      if (state != ST_IDLE && cmd_valid && is_initiate(cmd_func)) refuse = 1'b1;
      unique case (state)
         ST_IDLE: if (cmd_valid && is_initiate(cmd_func)) begin
            accept = 1'b1;
            nxt    = ST_FETCH;
         end
         ST_FETCH: if (mem_gnt) begin
            load_cnt  = 1'b1;
            step_addr = 1'b1;
            if (cnt_word_zero) begin
               done = 1'b1;
               nxt  = ST_IDLE;
            end else begin
               nxt = to_dev_q ? ST_MRD : ST_DGET;
            end
         end
         ST_MRD: if (mem_gnt) begin
            cap_mem   = 1'b1;
            step_addr = 1'b1;
            nxt       = ST_DPUT;
         end
         ST_DPUT: if (dev_out_ready) begin
            dec_cnt = 1'b1;
            done    = cnt_last;
            nxt     = cnt_last ? ST_IDLE : ST_MRD;
         end
         ST_DGET: if (dev_in_valid) begin
            cap_dev = 1'b1;
            nxt     = ST_MWR;
         end
         ST_MWR: if (mem_gnt) begin
            step_addr = 1'b1;
            dec_cnt   = 1'b1;
            done      = cnt_last;
            nxt       = cnt_last ? ST_IDLE : ST_DGET;
         end
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         to_dev_q <= 1'b0;
      end else begin
         state <= nxt;
         if (accept) to_dev_q <= (cmd_func == FN_INIT_WR);
      end
   end
endmodule

// File: rtl/steal_flags.sv
module steal_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic done,
   input  logic irq_ack,
   input  logic accept,
   input  logic refuse,
   output logic irq,
   output logic rejected
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq      <= 1'b0;
         rejected <= 1'b0;
      end else begin
         if (done)         irq <= 1'b1;
         else if (irq_ack) irq <= 1'b0;
         if (refuse)       rejected <= 1'b1;
         else if (accept)  rejected <= 1'b0;
      end
   end
endmodule

// File: rtl/steal_chan.sv
module steal_chan
   import steal_pkg::*;
#(
   parameter int AW = 16,
   parameter int DW = 16,
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_valid,
   input  logic [2:0]    cmd_func,
   input  logic [AW-1:0] cmd_addr,
   output logic          busy,
   output logic          rejected,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata,
   input  logic          mem_gnt,
   output logic          dev_out_valid,
   output logic [DW-1:0] dev_out_data,
   input  logic          dev_out_ready,
   input  logic          dev_in_valid,
   input  logic [DW-1:0] dev_in_data,
   output logic          dev_in_ready,
   output logic          irq,
   input  logic          irq_ack
);
   generate
      if (AW < 2)  begin : g_bad_aw  $error("steal_chan: AW must be at least 2"); end
      if (DW < 1)  begin : g_bad_dw  $error("steal_chan: DW must be positive"); end
      if (CW < 1 || CW > DW) begin : g_bad_cw $error("steal_chan: CW must lie in 1..DW"); end
   endgenerate

   chan_state_e   state;
   logic          accept, refuse, done;
   logic          load_cnt, step_addr, dec_cnt, cap_mem, cap_dev;
   logic          cnt_last;
   logic [DW-1:0] word_q;
   logic [CW-1:0] cnt_word;

   assign cnt_word = mem_rdata[CW-1:0];

   steal_seq u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .cmd_valid     (cmd_valid),
      .cmd_func      (cmd_func),
      .mem_gnt       (mem_gnt),
      .cnt_word_zero (cnt_word == '0),
      .cnt_last      (cnt_last),
      .dev_out_ready (dev_out_ready),
      .dev_in_valid  (dev_in_valid),
      .state         (state),
      .accept        (accept),
      .refuse        (refuse),
      .done          (done),
      .load_cnt      (load_cnt),
      .step_addr     (step_addr),
      .dec_cnt       (dec_cnt),
      .cap_mem       (cap_mem),
      .cap_dev       (cap_dev)
   );

   steal_ptr #(.AW(AW), .CW(CW)) u_ptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_addr (accept),
      .addr_in   (cmd_addr),
      .step_addr (step_addr),
      .load_cnt  (load_cnt),
      .cnt_in    (cnt_word),
      .dec_cnt   (dec_cnt),
      .addr      (mem_addr),
      .cnt_last  (cnt_last)
   );

   steal_flags u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .done     (done),
      .irq_ack  (irq_ack),
      .accept   (accept),
      .refuse   (refuse),
      .irq      (irq),
      .rejected (rejected)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)       word_q <= '0;
      else if (cap_mem) word_q <= mem_rdata;
      else if (cap_dev) word_q <= dev_in_data;
   end

   assign busy          = (state != ST_IDLE);
   assign mem_req       = (state == ST_FETCH) || (state == ST_MRD) || (state == ST_MWR);
   assign mem_we        = (state == ST_MWR);
   assign mem_wdata     = word_q;
   assign dev_out_valid = (state == ST_DPUT);
   assign dev_out_data  = word_q;
   assign dev_in_ready  = (state == ST_DGET);
endmodule

// File: rtl/steal_chan_chk.sv
module steal_chan_chk
   import steal_pkg::*;
#(
   parameter int AW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cmd_valid,
   input logic [2:0]    cmd_func,
   input logic          busy,
   input logic          rejected,
   input logic          mem_req,
   input logic          mem_we,
   input logic [AW-1:0] mem_addr,
   input logic          mem_gnt,
   input logic          dev_out_valid,
   input logic          dev_in_ready,
   input logic          irq,
   input logic          irq_ack
);
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req && !dev_out_valid && !dev_in_ready);

   p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we));

   p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && $past(mem_req && mem_gnt) |-> mem_addr == $past(mem_addr) + AW'(1));

   p_one_side_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(dev_out_valid && dev_in_ready));

   p_end_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> irq);

   p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq && !irq_ack |=> irq);

   p_refuse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy && cmd_valid && is_initiate(cmd_func) |=> rejected && busy);
endmodule

bind steal_chan steal_chan_chk #(.AW(AW)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cmd_valid     (cmd_valid),
   .cmd_func      (cmd_func),
   .busy          (busy),
   .rejected      (rejected),
   .mem_req       (mem_req),
   .mem_we        (mem_we),
   .mem_addr      (mem_addr),
   .mem_gnt       (mem_gnt),
   .dev_out_valid (dev_out_valid),
   .dev_in_ready  (dev_in_ready),
   .irq           (irq),
   .irq_ack       (irq_ack)
);

// File: tb/steal_chan_tb.sv
module steal_chan_tb;
   localparam int AW = 8;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic [2:0]    cmd_func = 3'b000;
   logic [AW-1:0] cmd_addr = '0;
   logic          busy, rejected, mem_req, mem_we, mem_gnt;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata, mem_rdata, dev_out_data, dev_in_data;
   logic          dev_out_valid, dev_out_ready, dev_in_valid, dev_in_ready;
   logic          irq, irq_ack = 1'b0;

   logic [DW-1:0] mem [256];
   logic [DW-1:0] rx [16];
   int            rx_n, grants, dev_seq, stall, cyc, nchk, nfail, hold_err;

   steal_chan #(.AW(AW), .DW(DW), .CW(DW)) u_dut (.*);

   always #4 clk = ~clk;

   assign mem_rdata   = mem[mem_addr];
   assign dev_in_data = 16'hA000 + DW'(dev_seq);

   initial begin
      mem_gnt = 1'b0; dev_out_ready = 1'b0; dev_in_valid = 1'b0;
      forever begin
         @(negedge clk);
         mem_gnt       = (cyc % (stall + 1)) == 0;
         dev_out_ready = ((cyc + 1) % (stall + 2)) != 0;
         dev_in_valid  = ((cyc + 2) % (stall + 2)) != 0;
      end
   end

   logic          prev_wait;
   logic [AW-1:0] prev_addr;
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (rst_n) begin
         if (mem_req && mem_gnt) grants <= grants + 1;
         if (mem_req && mem_gnt && mem_we) mem[mem_addr] <= mem_wdata;
         if (dev_out_valid && dev_out_ready) begin
            if (rx_n < 16) rx[rx_n] <= dev_out_data;
            rx_n <= rx_n + 1;
         end
         if (dev_in_valid && dev_in_ready) dev_seq <= dev_seq + 1;
         if (prev_wait && (!mem_req || mem_addr != prev_addr)) hold_err <= hold_err + 1;
      end
      prev_wait <= rst_n && mem_req && !mem_gnt;
      prev_addr <= mem_addr;
      if (cyc > 150000) begin
         nchk++; nfail++;
         $display("FAIL watchdog actual=%0d expected<=150000", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] seed(input int i);
      return DW'(16'h5000 ^ (i * 13));
   endfunction

   task automatic fill();
      for (int i = 0; i < 256; i++) mem[i] = seed(i);
   endtask

   task automatic issue(input logic [2:0] f, input int a);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_func = f; cmd_addr = AW'(a);
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic wait_irq();
      int t = 0;
      while (!irq && t < 3000) begin @(negedge clk); t++; end
      chk(irq == 1'b1, "R7 irq raised", irq, 1);
   endtask

   task automatic ack();
      @(negedge clk); irq_ack = 1'b1;
      @(negedge clk); irq_ack = 1'b0;
      chk(irq == 1'b0, "R7 irq cleared by ack", irq, 0);
   endtask

   task automatic run(input bit wr, input int n, input int base, input int st);
      int bad = 0;
      stall = st;
      fill();
      mem[base] = DW'(n);
      rx_n = 0; grants = 0; dev_seq = 0;
      issue(wr ? 3'b101 : 3'b110, base);
      chk(busy == 1'b1, "R1 initiate starts", busy, 1);
      wait_irq();
      chk(busy == 1'b0, "R7 busy low at end", busy, 0);
      chk(grants == n + 1, "R6 storage cycles N+1", grants, n + 1);
      if (wr) begin
         for (int k = 0; k < n; k++) if (rx[k] !== seed(base + 1 + k)) bad++;
         chk(rx_n == n && bad == 0, n == 0 ? "R2 zero count moves nothing" : "R3 write block order",
             rx_n * 256 + bad, n * 256);
      end else begin
         for (int k = 0; k < n; k++) if (mem[base + 1 + k] !== DW'(16'hA000 + k)) bad++;
         if (mem[base + 1 + n] !== seed(base + 1 + n)) bad++;
         chk(dev_seq == n && bad == 0, n == 0 ? "R2 zero count moves nothing" : "R4 read block order",
             dev_seq * 256 + bad, n * 256);
      end
      repeat (3) @(negedge clk);
      chk(irq == 1'b1, "R7 irq held without ack", irq, 1);
      ack();
   endtask

   initial begin
      stall = 0; cyc = 0; nchk = 0; nfail = 0; hold_err = 0;
      rx_n = 0; grants = 0; dev_seq = 0; prev_wait = 1'b0; prev_addr = '0;
      fill();
      repeat (3) @(negedge clk);
      chk(busy == 0 && irq == 0 && mem_req == 0 && rejected == 0, "R1 reset state",
          {busy, irq, mem_req, rejected}, 0);
      rst_n = 1'b1;

      // R1: non-initiate codes are ignored
      for (int f = 0; f < 8; f++) begin
         if (f == 5 || f == 6) continue;
         grants = 0;
         issue(3'(f), 8'h10);
         repeat (4) @(negedge clk);
         chk(busy == 0 && grants == 0 && irq == 0, "R1 other code ignored", {busy, irq} + grants, 0);
      end

      // R2 R3 R4 R6 R7: sweep directions, counts and stall patterns
      for (int wr = 0; wr < 2; wr++)
         for (int st = 0; st < 3; st++)
            for (int n = 0; n < 6; n++)
               run(wr[0], n, 16 + n * 24 + st * 3, st);

      // R8: initiate while busy is refused and leaves its target untouched
      stall = 2; fill();
      mem[8'h20] = 16'd4; mem[8'h80] = 16'd3;
      rx_n = 0; grants = 0; dev_seq = 0;
      issue(3'b101, 8'h20);
      repeat (3) @(negedge clk);
      issue(3'b110, 8'h80);
      chk(rejected == 1'b1, "R8 rejected flag set", rejected, 1);
      wait_irq();
      chk(rx_n == 4 && rx[3] == seed(8'h24), "R8 running block intact", rx_n, 4);
      chk(mem[8'h81] == seed(8'h81) && dev_seq == 0, "R8 refused target unwritten", mem[8'h81], seed(8'h81));
      chk(grants == 5, "R8 no extra storage cycles", grants, 5);
      ack();
      chk(rejected == 1'b1, "R8 flag kept until next accept", rejected, 1);
      mem[8'h40] = 16'd0;
      issue(3'b110, 8'h40);
      chk(rejected == 1'b0, "R8 flag cleared on accept", rejected, 0);
      wait_irq();
      ack();

      chk(hold_err == 0, "R5 request held until grant", hold_err, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end
endmodule